// File: doc/BRIEF.md
# External Interrupt Request Detector

This block watches a bank of asynchronous external interrupt lines and turns each one into a latched request for an interrupt controller. Every line first crosses into the system clock domain through a flop synchronizer. A per-line two-bit sense mode then picks what counts as an event: a low level, a falling edge, a rising edge or either edge. A detected event sets that line's status flag. The flag stays set until software pulses that line's clear strobe.

A line requests service only while its flag and its enable bit are both 1. The block also presents a fixed vector number for each line: line n carries 16+n. It has no knowledge of pin direction, so detection works the same whatever the pad is configured as. Priority among lines, CPU masking and the vector fetch belong to the interrupt controller.

Software loads the sense modes and the enables through two whole-bank write strobes. Flags are cleared per line.

Top module: `ext_irq_detect`

## Requirements
- R1: After reset all flags, enables and sense modes are 0, `irq_req` is 0, and the synchronizer holds every line at its idle high value, so a line that is high through reset sets no flag.
- R2: Sense code 00 (low level) sets the line's flag on every clock while the synchronized input is low. A clear strobe in such a cycle is overridden. Once the input is back high, a clear leaves the flag at 0.
- R3: Sense code 01 (falling edge) sets the flag on a high-to-low transition only, and does not set it again while the input stays low.
- R4: Sense code 10 (rising edge) sets the flag on a low-to-high transition only. A falling transition leaves the flag at 0.
- R5: Sense code 11 (both edges) sets the flag on either transition.
- R6: An input transition driven between two clock edges is seen in the flag after the third following rising clock edge, and not after the second.
- R7: A set flag holds until its clear strobe is sampled high. A clear in a cycle with no detection makes the flag 0 after that edge.
- R8: When a clear strobe and a detection on the same line fall on the same edge, the flag is 1 afterwards.
- R9: `irq_req[n]` is 1 exactly when flag n and enable n are both 1. Writing an enable of 0 drops the request on the next cycle, while the flag stays set.
- R10: `irq_vec[8n+7:8n]` carries the vector number 16+n for line n, so line 0 is 16 and line 7 is 23.
- R11: `en_we` loads `en_wdata` into the enables. `sense_we` loads `sense_wdata` into the sense modes, with line n's code in bits [2n+1:2n]. A line whose enable is 0 still sets its flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_in | input | 8 | Asynchronous external interrupt lines, bit n is line n |
| sense_we | input | 1 | Load strobe for the sense-mode register |
| sense_wdata | input | 16 | Sense codes, two bits per line |
| en_we | input | 1 | Load strobe for the enable register |
| en_wdata | input | 8 | Enable bits, one per line |
| flag_clr | input | 8 | Per-line clear strobe for the status flags |
| flag_q | output | 8 | Status flags |
| en_q | output | 8 | Current enable bits |
| irq_req | output | 8 | Requests to the interrupt controller |
| irq_vec | output | 64 | Vector number of each line, 8 bits per line |

## Verification
On every cycle, the assertions check three things about the flag latch: a detection always leaves the flag set, an uncleared flag holds, and a clear with no detection empties it. They also check that writing an enable of 0 silences the request on the next cycle. The sense decoding itself, the three-edge latency through the synchronizer and the fixed vector numbers can only be shown by the bench. It drives directed transitions in each mode, then a random run that mixes pin toggles, clears and configuration writes, compared against a bench model.

// File: rtl/irq_pkg.sv
package irq_pkg;
  typedef enum logic [1:0] {
    SENSE_LOW  = 2'b00,
    SENSE_FALL = 2'b01,
    SENSE_RISE = 2'b10,
    SENSE_BOTH = 2'b11
  } sense_e;
endpackage

// File: rtl/irq_sync.sv
// Multi-flop synchronizer for a bank of lines, plus a delayed copy for edge detection.
module irq_sync #(
  parameter int N      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] din,
  output logic [N-1:0] cur,
  output logic [N-1:0] prev
);
  logic [N-1:0] st [STAGES];
  logic [N-1:0] prev_q;

  // idle-high reset keeps lines that are high through reset from producing an edge
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < STAGES; k++) st[k] <= '1;
      prev_q <= '1;
    end else begin
      st[0] <= din;
      for (int k = 1; k < STAGES; k++) st[k] <= st[k-1];
      prev_q <= st[STAGES-1];
    end
  end

  assign cur  = st[STAGES-1];
  assign prev = prev_q;
endmodule

// File: rtl/irq_line.sv
// One line: sense decoding and the set-dominant status flag.
module irq_line
  import irq_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  sense_e sense,
  input  logic   cur,
  input  logic   prev,
  input  logic   clr,
  output logic   flag
);
  logic hit;
  logic flag_q;

  always_comb begin
    unique case (sense)
      SENSE_LOW:  hit = ~cur;
      SENSE_FALL: hit = prev & ~cur;
      SENSE_RISE: hit = ~prev & cur;
      SENSE_BOTH: hit = prev ^ cur;
      default:    hit = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) flag_q <= 1'b0;
    else     flag_q <= hit | (flag_q & ~clr);
  end

  assign flag = flag_q;

  AST_SET_WINS: assert property (@(posedge clk) disable iff (rst) hit |=> flag); // R8
  AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (rst) (flag && !clr) |=> flag); // R7
  AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (rst) (clr && !hit) |=> !flag); // R7
endmodule

// File: rtl/irq_vec_map.sv
// Fixed vector numbers, base plus line index.
module irq_vec_map #(
  parameter int N     = 8,
  parameter int BASE  = 16,
  parameter int VEC_W = 8
) (
  output logic [N*VEC_W-1:0] vec
);
  for (genvar i = 0; i < N; i++) begin : g_vec
    assign vec[i*VEC_W +: VEC_W] = VEC_W'(BASE + i);
  end
endmodule

// File: rtl/ext_irq_detect.sv
module ext_irq_detect
  import irq_pkg::*;
#(
  parameter int NUM_LINES   = 8,
  parameter int SYNC_STAGES = 2,
  parameter int VEC_BASE    = 16,
  parameter int VEC_W       = 8
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [NUM_LINES-1:0]       pin_in,
  input  logic                       sense_we,
  input  logic [2*NUM_LINES-1:0]     sense_wdata,
  input  logic                       en_we,
  input  logic [NUM_LINES-1:0]       en_wdata,
  input  logic [NUM_LINES-1:0]       flag_clr,
  output logic [NUM_LINES-1:0]       flag_q,
  output logic [NUM_LINES-1:0]       en_q,
  output logic [NUM_LINES-1:0]       irq_req,
  output logic [NUM_LINES*VEC_W-1:0] irq_vec
);
  localparam int SENSE_W = 2 * NUM_LINES;

  logic [SENSE_W-1:0]   sense_q;
  logic [NUM_LINES-1:0] en_r;
  logic [NUM_LINES-1:0] s_cur, s_prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      sense_q <= '0;
      en_r    <= '0;
    end else begin
      if (sense_we) sense_q <= sense_wdata;
      if (en_we)    en_r    <= en_wdata;
    end
  end

  irq_sync #(.N(NUM_LINES), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .din(pin_in), .cur(s_cur), .prev(s_prev)
  );

  for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
    irq_line u_line (
      .clk  (clk),
      .rst  (rst),
      .sense(sense_e'(sense_q[2*i +: 2])),
      .cur  (s_cur[i]),
      .prev (s_prev[i]),
      .clr  (flag_clr[i]),
      .flag (flag_q[i])
    );
  end

  irq_vec_map #(.N(NUM_LINES), .BASE(VEC_BASE), .VEC_W(VEC_W)) u_vec (
    .vec(irq_vec)
  );

  assign en_q    = en_r;
  assign irq_req = flag_q & en_r;

  AST_DISABLE_DROPS_REQ: assert property (@(posedge clk) disable iff (rst)
    (en_we && en_wdata == '0) |=> (irq_req == '0)); // R9
  AST_ENABLE_LOAD: assert property (@(posedge clk) disable iff (rst)
    en_we |=> (en_q == $past(en_wdata))); // R11
endmodule

// File: tb/sim_ext_irq_detect.sv
module sim_ext_irq_detect;
  localparam int N = 8;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [N-1:0] pin_in = '1;
  logic         sense_we = 1'b0;
  logic [2*N-1:0] sense_wdata = '0;
  logic         en_we = 1'b0;
  logic [N-1:0] en_wdata = '0;
  logic [N-1:0] flag_clr = '0;
  logic [N-1:0] flag_q, en_q, irq_req;
  logic [N*8-1:0] irq_vec;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  ext_irq_detect u0 (
    .clk(clk), .rst(rst), .pin_in(pin_in), .sense_we(sense_we), .sense_wdata(sense_wdata),
    .en_we(en_we), .en_wdata(en_wdata), .flag_clr(flag_clr), .flag_q(flag_q), .en_q(en_q),
    .irq_req(irq_req), .irq_vec(irq_vec)
  );

  // bench model built from the requirements
  logic [N-1:0]   m_s1, m_s2, m_pv, m_flag, m_en;
  logic [2*N-1:0] m_sense;

  function automatic logic exp_hit(logic [1:0] mode, logic c, logic p);
    case (mode)
      2'b00:   return !c;
      2'b01:   return p && !c;
      2'b10:   return !p && c;
      default: return p != c;
    endcase
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_s1 <= '1; m_s2 <= '1; m_pv <= '1;
      m_flag <= '0; m_en <= '0; m_sense <= '0;
    end else begin
      m_s1 <= pin_in; m_s2 <= m_s1; m_pv <= m_s2;
      for (int i = 0; i < N; i++)
        m_flag[i] <= exp_hit(m_sense[2*i +: 2], m_s2[i], m_pv[i]) | (m_flag[i] & ~flag_clr[i]);
      if (en_we)    m_en    <= en_wdata;
      if (sense_we) m_sense <= sense_wdata;
    end
  end

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n = 1);
    for (int k = 0; k < n; k++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic write_sense(input logic [2*N-1:0] v);
    sense_wdata = v; sense_we = 1'b1; tick(); sense_we = 1'b0;
  endtask

  task automatic write_en(input logic [N-1:0] v);
    en_wdata = v; en_we = 1'b1; tick(); en_we = 1'b0;
  endtask

  task automatic pulse_clr(input logic [N-1:0] v);
    flag_clr = v; tick(); flag_clr = '0;
  endtask

  initial begin
    #(200000 * 10);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=running expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [63:0] vexp;
    void'($urandom(32'd2024));
    tick(3);
    rst = 1'b0;
    tick(4);
    // R1: reset state, lines idle high
    check(flag_q == '0, "R1 flags", flag_q, 0);
    check(irq_req == '0 && en_q == '0, "R1 req/en", {irq_req, en_q}, 0);
    // R10: vector numbers
    vexp = '0;
    for (int i = 0; i < N; i++) vexp[i*8 +: 8] = 8'(16 + i);
    check(irq_vec == vexp, "R10 vectors", irq_vec, vexp);

    // line0 falling, line1 rising, line2 both, line3 low level
    write_sense(16'b00_00_00_00_00_11_10_01);
    write_en('1);
    check(en_q == '1, "R11 enable load", en_q, 8'hff);

    // R3 / R6 falling edge latency
    pin_in[0] = 1'b0;
    tick(2);
    check(flag_q[0] == 1'b0, "R6 not after two edges", flag_q[0], 0);
    tick();
    check(flag_q[0] == 1'b1, "R3 R6 falling sets", flag_q[0], 1);
    check(irq_req[0] == 1'b1, "R9 request", irq_req[0], 1);
    tick(4);
    check(flag_q[0] == 1'b1, "R7 holds", flag_q[0], 1);
    pulse_clr(8'h01);
    check(flag_q[0] == 1'b0, "R7 clear", flag_q[0], 0);
    tick(3);
    check(flag_q[0] == 1'b0, "R3 no retrigger while low", flag_q[0], 0);

    // R4 rising edge only
    pin_in[1] = 1'b0; tick(3);
    check(flag_q[1] == 1'b0, "R4 falling ignored", flag_q[1], 0);
    pin_in[1] = 1'b1; tick(3);
    check(flag_q[1] == 1'b1, "R4 rising sets", flag_q[1], 1);

    // R5 both edges
    pin_in[2] = 1'b0; tick(3);
    check(flag_q[2] == 1'b1, "R5 falling sets", flag_q[2], 1);
    pulse_clr(8'h04);
    check(flag_q[2] == 1'b0, "R5 cleared", flag_q[2], 0);
    pin_in[2] = 1'b1; tick(3);
    check(flag_q[2] == 1'b1, "R5 rising sets", flag_q[2], 1);

    // R2 low level, clear overridden while low
    pin_in[3] = 1'b0; tick(3);
    check(flag_q[3] == 1'b1, "R2 low sets", flag_q[3], 1);
    pulse_clr(8'h08);
    check(flag_q[3] == 1'b1, "R2 clear overridden", flag_q[3], 1);
    pin_in[3] = 1'b1; tick(3);
    pulse_clr(8'h08);
    check(flag_q[3] == 1'b0, "R2 clear after release", flag_q[3], 0);

    // R8 clear and detection on the same edge
    pin_in[0] = 1'b1; tick(3);
    check(flag_q[0] == 1'b0, "R3 rising ignored", flag_q[0], 0);
    pin_in[0] = 1'b0; tick(2);
    pulse_clr(8'h01);
    check(flag_q[0] == 1'b1, "R8 set wins", flag_q[0], 1);

    // R9 / R11 enable gating, flag still sets while disabled
    write_en(8'h00);
    check(irq_req == '0, "R9 disabled drops req", irq_req, 0);
    check(flag_q[0] == 1'b1, "R9 flag kept", flag_q[0], 1);
    pin_in[4] = 1'b0; tick(3);
    check(flag_q[4] == 1'b1 && irq_req[4] == 1'b0, "R11 sets while disabled",
          {flag_q[4], irq_req[4]}, 2'b10);
    write_en(8'h01);
    check(irq_req == 8'h01, "R9 reenable", irq_req, 8'h01);

    // random phase against the model
    for (int c = 0; c < 3000; c++) begin
      pin_in   = pin_in ^ (N'($urandom) & N'($urandom));
      flag_clr = N'($urandom) & N'($urandom) & N'($urandom);
      sense_we = ($urandom % 16) == 0;
      sense_wdata = (2*N)'($urandom);
      en_we    = ($urandom % 16) == 0;
      en_wdata = N'($urandom);
      tick();
      check(flag_q == m_flag, "R7 R8 random flags", flag_q, m_flag);
      check(irq_req == (m_flag & m_en), "R9 random req", irq_req, m_flag & m_en);
    end
    flag_clr = '0; sense_we = 1'b0; en_we = 1'b0;

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule